// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits between one bus master and the memory fabric. Two address windows act as bit aliases: every aligned word in a window stands for one bit of a backing byte elsewhere in the map. A read of an alias word returns that single bit as the value 0 or 1. A write to an alias word changes only that bit. The write is done as a read-modify-write of the whole backing word, and the memory side stays locked from the read until the write is acknowledged. Accesses outside both windows pass straight through in the same cycle. So do accesses for which the master-select input says they come from some other master.

The master side is a simple request/acknowledge port. The master raises `m_req` with `m_we`, `m_addr` and `m_wdata`, and holds them steady until the cycle in which `m_ack` is high. It changes them only after that clock edge. The memory side uses the same handshake (`s_req`/`s_ack`), and `s_rdata` is valid in the acknowledge cycle. The alias path runs on a four-state machine:

- IDLE forwards pass-through traffic. It moves to FETCH when an aliased request arrives, latching the backing word address, the bit position, the direction and bit 0 of the write data.
- FETCH issues a locked read. When that read is acknowledged, the machine moves to STORE if the access is a write and to REPLY if it is a read.
- STORE issues a locked write of the modified word. When that write is acknowledged, the machine moves to REPLY.
- REPLY acknowledges the master for one cycle and returns to IDLE.

Top module: `bitband_xlate`

## Requirements
- R1: When `m_core` is 1 and `m_addr` lies outside both alias windows, the master request is forwarded to the memory side in the same cycle. `s_addr`, `s_we` and `s_wdata` equal the master values, `m_ack` follows `s_ack`, `m_rdata` follows `s_rdata`, and `s_lock` stays 0.
- R2: The SRAM alias window covers 0x2200_0000 to 0x221F_FFFF. With offset o = addr − 0x2200_0000, the backing byte is 0x2000_0000 + o/32 and the bit number is o[4:2]. The backing word address is that byte address with bits [1:0] cleared. Memory is little-endian, so the bit position within the word is (byte address mod 4)×8 + bit number. For example, 0x2200_6008 maps to word 0x2000_0300, bit 2.
- R3: The peripheral alias window covers 0x4200_0000 to 0x425F_FFFF. It maps onto 0x4000_0000 using the same formula as R2.
- R4: An aliased read performs exactly one memory read of the backing word. It then returns 0x0000_0001 or 0x0000_0000 on `m_rdata`, according to the target bit.
- R5: An aliased write performs one read of the backing word, then one write to the same address. The data written equals the word that was read, with only the target bit replaced by bit 0 of `m_wdata`. The reply data is 0.
- R6: `s_lock` is 1 during both memory phases of an aliased access, with no gap between them, and 0 for every pass-through access.
- R7: On an aliased access the master is stalled. `m_ack` rises only in the cycle after the last memory acknowledge, and stays high for exactly one cycle.
- R8: After reset with no request pending, the block is idle and `m_ack`, `s_req` and `s_lock` are 0.
- R9: When `m_core` is 0, addresses inside the alias windows pass through unchanged, exactly as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request |
| m_core | input | 1 | 1 when the request comes from the master that owns the alias view |
| m_we | input | 1 | Master write enable |
| m_addr | input | ADDR_W | Master byte address |
| m_wdata | input | DATA_W | Master write data |
| m_ack | output | 1 | Master acknowledge |
| m_rdata | output | DATA_W | Master read data |
| s_req | output | 1 | Memory request |
| s_we | output | 1 | Memory write enable |
| s_lock | output | 1 | Memory lock held across the read-modify-write |
| s_addr | output | ADDR_W | Memory byte address |
| s_wdata | output | DATA_W | Memory write data |
| s_ack | input | 1 | Memory acknowledge |
| s_rdata | input | DATA_W | Memory read data, valid with `s_ack` |

## Verification
A wrong internal state shows at the ports within a single transaction. A latched bit position or word address that has gone astray shows up on the first memory phase as a wrong `s_addr`. In the STORE phase it shows up as a `s_wdata` with a bit other than the target changed. A state machine that skips or repeats a phase shows up as a wrong number of memory transactions, or as `m_ack` arriving before the final memory acknowledge. A machine that fails to return to IDLE blocks the following pass-through access, and the watchdog catches that. Random alias and pass-through traffic with random memory latency is compared against a bench memory model, and a second read of each modified bit confirms the stored value.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_REPLY = 2'd3
    } bb_state_e;

endpackage

// File: rtl/bb_alias_dec.sv
// One alias window: hit detection and translation to backing word and bit.
module bb_alias_dec #(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 32,
    parameter int              POS_W       = $clog2(DATA_W),
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = '0,
    parameter logic [ADDR_W-1:0] ALIAS_SPAN  = '0,
    parameter logic [ADDR_W-1:0] TARGET_BASE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] word_addr,
    output logic [POS_W-1:0]  bit_pos
);
    localparam int LANE_B = $clog2(DATA_W / 8);   // byte lane index bits
    localparam int SHIFT  = $clog2(DATA_W);       // alias bytes per backing byte

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] byte_addr;

    assign offset    = addr - ALIAS_BASE;
    assign hit       = (offset < ALIAS_SPAN);
    assign byte_addr = TARGET_BASE + (offset >> SHIFT);
    assign word_addr = {byte_addr[ADDR_W-1:LANE_B], {LANE_B{1'b0}}};
    // little-endian: lane index selects the byte within the word
    assign bit_pos   = {byte_addr[LANE_B-1:0], offset[LANE_B+2:LANE_B]};
endmodule

// File: rtl/bb_bit_merge.sv
// Single-bit extract and replace on a data word.
module bb_bit_merge #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [POS_W-1:0]  pos,
    input  logic              new_bit,
    output logic [DATA_W-1:0] merged,
    output logic              picked
);
    always_comb begin
        merged      = word;
        merged[pos] = new_bit;
    end

    assign picked = word[pos];
endmodule

// File: rtl/bb_rmw_fsm.sv
// Sequencer for the locked read-modify-write on the memory side.
module bb_rmw_fsm
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      is_write,
    input  logic      mem_ack,
    output bb_state_e state,
    output logic      load,
    output logic      fetch_done,
    output logic      mem_req,
    output logic      mem_we,
    output logic      mem_lock,
    output logic      reply
);
    bb_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)   state_nx = ST_FETCH;
            ST_FETCH: if (mem_ack) state_nx = is_write ? ST_STORE : ST_REPLY;
            ST_STORE: if (mem_ack) state_nx = ST_REPLY;
            ST_REPLY:              state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load       = 1'b0;
        fetch_done = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_lock   = 1'b0;
        reply      = 1'b0;
        unique case (state)
            ST_IDLE:  load = start;
            ST_FETCH: begin
                mem_req    = 1'b1;
                mem_lock   = 1'b1;
                fetch_done = mem_ack;
            end
            ST_STORE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_lock = 1'b1;
            end
            ST_REPLY: reply = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bitband_xlate.sv
// Bit-band alias translator between one master and the memory side.
module bitband_xlate
    import bb_pkg::*;
#(
    parameter int                ADDR_W            = 32,
    parameter int                DATA_W            = 32,
    parameter logic [ADDR_W-1:0] SRAM_ALIAS_BASE   = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] SRAM_ALIAS_SPAN   = 32'h0020_0000,
    parameter logic [ADDR_W-1:0] SRAM_TARGET       = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] PERIPH_ALIAS_BASE = 32'h4200_0000,
    parameter logic [ADDR_W-1:0] PERIPH_ALIAS_SPAN = 32'h0060_0000,
    parameter logic [ADDR_W-1:0] PERIPH_TARGET     = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_core,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ack,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_req,
    output logic              s_we,
    output logic              s_lock,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_ack,
    input  logic [DATA_W-1:0] s_rdata
);
    localparam int POS_W   = $clog2(DATA_W);
    localparam int NUM_WIN = 2;
    localparam logic [ADDR_W-1:0] WIN_BASE [NUM_WIN] = '{SRAM_ALIAS_BASE, PERIPH_ALIAS_BASE};
    localparam logic [ADDR_W-1:0] WIN_SPAN [NUM_WIN] = '{SRAM_ALIAS_SPAN, PERIPH_ALIAS_SPAN};
    localparam logic [ADDR_W-1:0] WIN_TGT  [NUM_WIN] = '{SRAM_TARGET, PERIPH_TARGET};

    logic              win_hit  [NUM_WIN];
    logic [ADDR_W-1:0] win_word [NUM_WIN];
    logic [POS_W-1:0]  win_pos  [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        bb_alias_dec #(
            .ADDR_W     (ADDR_W),
            .DATA_W     (DATA_W),
            .POS_W      (POS_W),
            .ALIAS_BASE (WIN_BASE[g]),
            .ALIAS_SPAN (WIN_SPAN[g]),
            .TARGET_BASE(WIN_TGT[g])
        ) i_dec (
            .addr     (m_addr),
            .hit      (win_hit[g]),
            .word_addr(win_word[g]),
            .bit_pos  (win_pos[g])
        );
    end

    logic              any_hit;
    logic [ADDR_W-1:0] sel_word;
    logic [POS_W-1:0]  sel_pos;

    always_comb begin
        any_hit  = 1'b0;
        sel_word = '0;
        sel_pos  = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                any_hit  = 1'b1;
                sel_word = win_word[i];
                sel_pos  = win_pos[i];
            end
        end
    end

    // sequencer
    bb_state_e state;
    logic      alias_take, load, fetch_done;
    logic      fsm_req, fsm_we, fsm_lock, fsm_reply;
    logic      we_q, nbit_q;
    logic [ADDR_W-1:0] word_q;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] merged;
    logic              picked;

    assign alias_take = m_req && m_core && any_hit;

    bb_rmw_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (alias_take),
        .is_write  (we_q),
        .mem_ack   (s_ack),
        .state     (state),
        .load      (load),
        .fetch_done(fetch_done),
        .mem_req   (fsm_req),
        .mem_we    (fsm_we),
        .mem_lock  (fsm_lock),
        .reply     (fsm_reply)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            pos_q  <= '0;
            we_q   <= 1'b0;
            nbit_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (load) begin
                word_q <= sel_word;
                pos_q  <= sel_pos;
                we_q   <= m_we;
                nbit_q <= m_wdata[0];
            end
            if (fetch_done) data_q <= s_rdata;
        end
    end

    bb_bit_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) i_merge (
        .word   (data_q),
        .pos    (pos_q),
        .new_bit(nbit_q),
        .merged (merged),
        .picked (picked)
    );

    // port steering
    logic pass;
    assign pass = (state == ST_IDLE) && !alias_take;

    always_comb begin
        if (pass) begin
            s_req   = m_req;
            s_we    = m_we;
            s_addr  = m_addr;
            s_wdata = m_wdata;
            m_ack   = s_ack;
            m_rdata = s_rdata;
        end else begin
            s_req   = fsm_req;
            s_we    = fsm_we;
            s_addr  = word_q;
            s_wdata = merged;
            m_ack   = fsm_reply;
            m_rdata = we_q ? '0 : {{(DATA_W-1){1'b0}}, picked};
        end
        s_lock = fsm_lock;
    end
endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk
    import bb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input bb_state_e         state,
    input logic              s_we,
    input logic              s_lock,
    input logic              s_ack,
    input logic [ADDR_W-1:0] s_addr,
    input logic              m_ack,
    input logic [DATA_W-1:0] m_rdata
);
    // write phase only directly after an acknowledged read phase
    p_store_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && $past(state) != ST_STORE) |-> $past(state == ST_FETCH && s_ack));

    // write phase targets the word that was read
    p_store_same_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lock && s_we) |-> (s_addr == $past(s_addr)));

    // lock not dropped while a phase waits
    p_lock_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lock && !s_ack) |=> s_lock);

    // reply only after the final locked memory acknowledge
    p_reply_after_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLY) |-> $past(s_ack && s_lock));

    // master not acknowledged while memory is locked
    p_no_ack_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock |-> !m_ack);

    // alias replies carry at most bit 0
    p_reply_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLY) |-> (m_rdata[DATA_W-1:1] == '0));
endmodule

bind bitband_xlate bb_xlate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .s_we   (s_we),
    .s_lock (s_lock),
    .s_ack  (s_ack),
    .s_addr (s_addr),
    .m_ack  (m_ack),
    .m_rdata(m_rdata)
);

// File: tb/test_bitband_xlate.sv
module test_bitband_xlate;
    localparam int CLK_HALF = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_core = 1'b1, m_we = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic        m_ack;
    logic [31:0] m_rdata;
    logic        s_req, s_we, s_lock;
    logic [31:0] s_addr, s_wdata;
    logic        s_ack = 1'b0;
    logic [31:0] s_rdata = '0;

    always #CLK_HALF clk = ~clk;

    bitband_xlate i_bitband_xlate (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_core(m_core), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata),
        .s_req(s_req), .s_we(s_we), .s_lock(s_lock), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ack(s_ack), .s_rdata(s_rdata)
    );

    int checks = 0;
    int errors = 0;

    // memory model with transaction log
    logic [31:0] mem [logic [31:0]];
    logic [31:0] log_addr [8];
    logic [31:0] log_wd   [8];
    logic        log_we   [8];
    logic        log_lock [8];
    int          log_n = 0;
    int          lat_left = 0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    always @(negedge clk) begin
        if (!rst_n || !s_req || s_ack) begin
            s_ack    = 1'b0;
            lat_left = $urandom_range(0, 2);
        end else if (lat_left > 0) begin
            lat_left--;
        end else begin
            s_ack   = 1'b1;
            s_rdata = mem_rd(s_addr);
            if (log_n < 8) begin
                log_addr[log_n] = s_addr;
                log_wd[log_n]   = s_wdata;
                log_we[log_n]   = s_we;
                log_lock[log_n] = s_lock;
            end
            log_n++;
            if (s_we) mem[s_addr] = s_wdata;
        end
    end

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // reference translation from R2/R3
    function automatic void ref_map(input logic [31:0] a, output logic hit, output int win,
                                    output logic [31:0] w, output int pos);
        logic [31:0] b;
        hit = 1'b0; win = 0; b = '0;
        if (a >= 32'h2200_0000 && a < 32'h2220_0000) begin
            hit = 1'b1; win = 2; b = 32'h2000_0000 + ((a - 32'h2200_0000) >> 5);
        end else if (a >= 32'h4200_0000 && a < 32'h4260_0000) begin
            hit = 1'b1; win = 3; b = 32'h4000_0000 + ((a - 32'h4200_0000) >> 5);
        end
        w   = b & ~32'h3;
        pos = int'(b[1:0]) * 8 + int'(a[4:2]);
    endfunction

    task automatic access(input logic core, input logic we, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd, output int n_at_ack);
        @(posedge clk); #1;
        log_n  = 0;
        m_core = core; m_we = we; m_addr = addr; m_wdata = wd; m_req = 1'b1;
        forever begin
            @(negedge clk); #5;
            if (m_ack) break;
        end
        rd = m_rdata;
        n_at_ack = log_n;
        @(posedge clk); #1;
        m_req = 1'b0;
        @(negedge clk); #5;
        chk_eq("R7 ack is a single pulse", {31'b0, m_ack}, 32'h0);
    endtask

    task automatic run(input logic core, input logic we, input logic [31:0] addr, input logic [31:0] wd);
        logic        hit;
        int          win, pos, nack;
        logic [31:0] w, old, rd, expw;
        string       rq;
        ref_map(addr, hit, win, w, pos);
        if (core && hit) begin
            rq  = (win == 2) ? "R2" : "R3";
            old = mem_rd(w);
            access(core, we, addr, wd, rd, nack);
            chk_eq("R7 ack after all memory phases", nack, we ? 2 : 1);
            chk_eq(we ? "R5 phase count" : "R4 phase count", log_n, we ? 2 : 1);
            chk_eq({rq, " backing word address"}, log_addr[0], w);
            chk_eq("R6 lock on read phase", {31'b0, log_lock[0]}, 32'h1);
            chk_eq("R4 first phase is a read", {31'b0, log_we[0]}, 32'h0);
            if (we) begin
                expw = old;
                expw[pos] = wd[0];
                chk_eq("R5 write phase address", log_addr[1], w);
                chk_eq("R5 second phase is a write", {31'b0, log_we[1]}, 32'h1);
                chk_eq("R6 lock on write phase", {31'b0, log_lock[1]}, 32'h1);
                chk_eq("R5 merged write data", log_wd[1], expw);
                chk_eq("R5 write reply data", rd, 32'h0);
            end else begin
                chk_eq({"R4 read bit via ", rq}, rd, {31'b0, old[pos]});
            end
        end else begin
            rq  = core ? "R1" : "R9";
            old = mem_rd(addr);
            access(core, we, addr, wd, rd, nack);
            chk_eq({rq, " single transaction"}, log_n, 1);
            chk_eq({rq, " address forwarded"}, log_addr[0], addr);
            chk_eq({rq, " direction forwarded"}, {31'b0, log_we[0]}, {31'b0, we});
            chk_eq("R6 no lock on pass-through", {31'b0, log_lock[0]}, 32'h0);
            if (we) chk_eq({rq, " write data forwarded"}, log_wd[0], wd);
            else    chk_eq({rq, " read data forwarded"}, rd, old);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          nack;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); #5;
        chk_eq("R8 m_ack in reset", {31'b0, m_ack}, 32'h0);
        chk_eq("R8 s_lock in reset", {31'b0, s_lock}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #5;
        chk_eq("R8 s_req idle after reset", {31'b0, s_req}, 32'h0);
        chk_eq("R8 m_ack idle after reset", {31'b0, m_ack}, 32'h0);
        chk_eq("R8 s_lock idle after reset", {31'b0, s_lock}, 32'h0);

        // directed R2 example: bit 2 of byte 0x2000_0300
        mem[32'h2000_0300] = 32'h0000_0000;
        run(1'b1, 1'b1, 32'h2200_6008, 32'h0000_0001);
        chk_eq("R2 example bit set in memory", mem_rd(32'h2000_0300), 32'h0000_0004);
        access(1'b1, 1'b0, 32'h2200_6008, 32'h0, rd, nack);
        chk_eq("R4 example reads back 1", rd, 32'h1);
        run(1'b1, 1'b1, 32'h2200_6008, 32'hFFFF_FFFE);
        chk_eq("R5 bit cleared from wdata bit 0", mem_rd(32'h2000_0300), 32'h0);
        // top of each window, lane 3 bit 7
        run(1'b1, 1'b1, 32'h221F_FFFC, 32'h1);
        run(1'b1, 1'b0, 32'h221F_FFFC, 32'h0);
        run(1'b1, 1'b1, 32'h425F_FFFC, 32'h1);
        run(1'b1, 1'b0, 32'h4200_0000, 32'h0);
        // just outside the windows
        run(1'b1, 1'b0, 32'h4260_0000, 32'h0);
        run(1'b1, 1'b1, 32'h21FF_FFFC, 32'hCAFE_F00D);
        // another master on an alias address
        run(1'b0, 1'b1, 32'h2200_6008, 32'h1234_5679);
        run(1'b0, 1'b0, 32'h4200_0010, 32'h0);

        for (int k = 0; k < 300; k++) begin
            int          kind;
            logic        we;
            logic [31:0] a, wd;
            kind = $urandom_range(0, 3);
            we   = 1'($urandom_range(0, 1));
            wd   = $urandom;
            case (kind)
                0: a = 32'h2200_0000 + ($urandom & 32'h0000_03FF);
                1: a = 32'h4200_0000 + $urandom_range(0, 32'h005F_FFFF);
                2: a = 32'h2000_0000 + ($urandom & 32'h0000_FFFC);
                default: a = 32'h2200_0000 + ($urandom & 32'h001F_FFFF);
            endcase
            run((kind == 3) ? 1'b0 : 1'b1, we, a, wd);
        end

        summary();
        $finish;
    end
endmodule